// File: doc/BRIEF.md
# Power-Domain Register Access Proxy

This block lets a host reach registers that sit inside power-gated domains without the host itself keeping those domains awake. It appears to the host as two 32-bit registers on a simple register bus: a data register and a command register. The host packs a target offset, a read/write flag, a domain code and a launch bit into one command write. The engine then wakes the chosen domain or domains through a request/acknowledge handshake. It performs one dword access on a target register port and drops the wake requests. Finally it clears the launch bit, which tells the host the access is done.

For a store, the host loads the data register and then issues the command. For a load, the host issues the command and polls the command register until the launch bit reads back 0. The fetched dword is then waiting in the data register. A wider value is moved as several commands at consecutive 4-byte offsets. Host reads are answered combinationally in the same cycle, so the host bus never waits on the proxy.

Top module: `regproxy_top`

## Requirements
- R1: After reset the data and command registers read 0, and no wake request and no target request are asserted.
- R2: The data register is at host offset 0xF00 and the command register at 0xF04. Command bit 31 is GO, bits 29:28 the domain code, bit 24 the operation (1 = read, 0 = write) and bits 23:0 the target offset. Bits 30 and 27:25 read as 0, and any other host offset reads 0.
- R3: A write command drives exactly the 24-bit target offset on the target port with the write flag set, and the data register contents as write data.
- R4: After a read command completes, the data register holds the dword that the target returned.
- R5: Wake request bit 0 is blitter, bit 1 render and bit 2 media. Domain codes 0, 1 and 2 raise only their own bit, and code 3 raises all three. No wake request is raised while GO is 0.
- R6: No target request is issued until every selected domain has acknowledged its wake request.
- R7: Wake requests stay asserted through the target access and are all low in the cycle GO clears. GO clears in the same cycle that read data is latched.
- R8: Host writes to either register while GO is 1 have no effect.
- R9: Each command performs exactly one target handshake. A pending target request holds its offset until acknowledged.
- R10: Writing the command register with GO at 0 stores the fields but starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 12 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| wake_req | output | 3 | Per-domain wake request (bit 0 blitter, 1 render, 2 media) |
| wake_ack | input | 3 | Per-domain wake acknowledge |
| tgt_req | output | 1 | Target access request, held until tgt_ack |
| tgt_we | output | 1 | Target access is a write |
| tgt_addr | output | 24 | Target register offset |
| tgt_wdata | output | 32 | Target write data |
| tgt_rdata | input | 32 | Target read data, valid with tgt_ack |
| tgt_ack | input | 1 | Target access complete |

## Verification
A wrong sequencer state shows at the ports within a few cycles of launch. Depending on the fault, a target request appears before the acknowledges arrive, a wake bit outside the decoded mask is raised, GO stays high past its poll limit, or a second target handshake appears for one command. A corrupted data or command register shows on the next host read, because both are returned combinationally. To expose the ignore-while-busy rule, the bench stalls one domain's acknowledge and overwrites both registers during the stall. It then reads back the registers and the target offset once the access finishes.

// File: rtl/regproxy_pkg.sv
package regproxy_pkg;
  localparam int NUM_DOM  = 3;
  localparam int OFS_W    = 24;
  localparam int WORD_W   = 32;
  localparam int GO_BIT   = 31;
  localparam int DOM_LSB  = 28;
  localparam int OP_BIT   = 24;
  localparam logic [WORD_W-1:0] CMD_KEEP = 32'hB1FF_FFFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } seq_st_e;

  // domain code to wake mask: blitter=bit0, render=bit1, media=bit2, 3=all
  function automatic logic [NUM_DOM-1:0] dom_mask(input logic [1:0] code);
    logic [NUM_DOM-1:0] m;
    if (code == 2'd3) m = '1;
    else begin
      m = '0;
      m[code] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] cmd_clean(input logic [WORD_W-1:0] w);
    return w & CMD_KEEP;
  endfunction
endpackage

// File: rtl/regproxy_regs.sv
module regproxy_regs
  import regproxy_pkg::*;
#(
  parameter int HOST_AW = 12,
  parameter logic [HOST_AW-1:0] DATA_OFS = 12'hF00,
  parameter logic [HOST_AW-1:0] CMD_OFS  = 12'hF04
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  input  logic               done,
  input  logic               done_rd,
  input  logic [WORD_W-1:0]  done_rdata,
  output logic [WORD_W-1:0]  host_rdata,
  output logic [WORD_W-1:0]  data_q,
  output logic [WORD_W-1:0]  cmd_q
);
  logic busy;
  logic wr_data_ok;
  logic wr_cmd_ok;

  assign busy       = cmd_q[GO_BIT];
  assign wr_data_ok = host_wr_en && !busy && (host_addr == DATA_OFS);
  assign wr_cmd_ok  = host_wr_en && !busy && (host_addr == CMD_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (wr_data_ok) data_q <= host_wdata;
      else if (done && done_rd) data_q <= done_rdata;
      if (wr_cmd_ok) cmd_q <= cmd_clean(host_wdata);
      else if (done) cmd_q[GO_BIT] <= 1'b0;
    end
  end

  always_comb begin
    if (host_addr == DATA_OFS)     host_rdata = data_q;
    else if (host_addr == CMD_OFS) host_rdata = cmd_q;
    else                           host_rdata = '0;
  end

  // R8
  data_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(data_q));
  // R8
  cmd_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cmd_q));
  // R7
  go_clears_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
endmodule

// File: rtl/regproxy_wake.sv
module regproxy_wake
  import regproxy_pkg::*;
(
  input  logic               enable,
  input  logic [NUM_DOM-1:0] mask,
  input  logic [NUM_DOM-1:0] wake_ack,
  output logic [NUM_DOM-1:0] wake_req,
  output logic               ready
);
  logic [NUM_DOM-1:0] dom_ok;

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    assign wake_req[i] = enable && mask[i];
    assign dom_ok[i]   = !mask[i] || wake_ack[i];
  end

  assign ready = &dom_ok;
endmodule

// File: rtl/regproxy_seq.sv
module regproxy_seq
  import regproxy_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [1:0]         dom_code,
  input  logic               op_rd,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic               wake_ready,
  output logic               wake_en,
  output logic [NUM_DOM-1:0] mask_q,
  output logic               tgt_req,
  output logic               tgt_we,
  output logic [OFS_W-1:0]   tgt_addr,
  output logic [WORD_W-1:0]  tgt_wdata,
  input  logic [WORD_W-1:0]  tgt_rdata,
  input  logic               tgt_ack,
  output logic               done,
  output logic               done_rd,
  output logic [WORD_W-1:0]  done_rdata
);
  seq_st_e st_q;
  logic    rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      mask_q     <= '0;
      rd_q       <= 1'b0;
      tgt_addr   <= '0;
      tgt_wdata  <= '0;
      done_rdata <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go) begin
          mask_q    <= dom_mask(dom_code);
          rd_q      <= op_rd;
          tgt_addr  <= ofs;
          tgt_wdata <= wr_word;
          st_q      <= ST_WAKE;
        end
        ST_WAKE: if (wake_ready) st_q <= ST_XFER;
        ST_XFER: if (tgt_ack) begin
          done_rdata <= tgt_rdata;
          st_q       <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wake_en = (st_q == ST_WAKE) || (st_q == ST_XFER);
  assign tgt_req = (st_q == ST_XFER);
  assign tgt_we  = !rd_q;
  assign done    = (st_q == ST_DONE);
  assign done_rd = rd_q;

  // R6
  no_xfer_before_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> wake_ready);
  // R9
  req_held_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_addr)));
endmodule

// File: rtl/regproxy_top.sv
module regproxy_top
  import regproxy_pkg::*;
#(
  parameter int HOST_AW = 12,
  parameter logic [HOST_AW-1:0] DATA_OFS = 12'hF00,
  parameter logic [HOST_AW-1:0] CMD_OFS  = 12'hF04
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic [2:0]         wake_req,
  input  logic [2:0]         wake_ack,
  output logic               tgt_req,
  output logic               tgt_we,
  output logic [23:0]        tgt_addr,
  output logic [31:0]        tgt_wdata,
  input  logic [31:0]        tgt_rdata,
  input  logic               tgt_ack
);
  logic [WORD_W-1:0]  data_q;
  logic [WORD_W-1:0]  cmd_q;
  logic               done;
  logic               done_rd;
  logic [WORD_W-1:0]  done_rdata;
  logic               wake_en;
  logic               wake_ready;
  logic [NUM_DOM-1:0] mask_q;

  regproxy_regs #(.HOST_AW(HOST_AW), .DATA_OFS(DATA_OFS), .CMD_OFS(CMD_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .done(done), .done_rd(done_rd), .done_rdata(done_rdata),
    .host_rdata(host_rdata), .data_q(data_q), .cmd_q(cmd_q)
  );

  regproxy_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(cmd_q[GO_BIT]),
    .dom_code(cmd_q[DOM_LSB+1:DOM_LSB]), .op_rd(cmd_q[OP_BIT]),
    .ofs(cmd_q[OFS_W-1:0]), .wr_word(data_q), .wake_ready(wake_ready),
    .wake_en(wake_en), .mask_q(mask_q), .tgt_req(tgt_req), .tgt_we(tgt_we),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
    .tgt_ack(tgt_ack), .done(done), .done_rd(done_rd), .done_rdata(done_rdata)
  );

  regproxy_wake u_wake (
    .enable(wake_en), .mask(mask_q), .wake_ack(wake_ack),
    .wake_req(wake_req), .ready(wake_ready)
  );

  // R5
  wake_only_when_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req != '0) |-> cmd_q[GO_BIT]);
  // R7
  wake_low_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wake_req == '0));
  // R3
  wdata_matches_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && tgt_we) |-> (tgt_wdata == data_q));
endmodule

// File: tb/regproxy_top_tb.sv
module regproxy_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_DATA = 12'hF00;
  localparam logic [11:0] A_CMD  = 12'hF04;
  localparam int NV = 8;
  // {dom[1:0], rd, ofs[23:0], wdata[31:0]}
  localparam logic [58:0] VEC [NV] = '{
    {2'd1, 1'b0, 24'h000100, 32'hA5A5_0001},
    {2'd2, 1'b0, 24'h000104, 32'h1234_5678},
    {2'd0, 1'b1, 24'h000100, 32'h0},
    {2'd3, 1'b1, 24'h000104, 32'h0},
    {2'd3, 1'b0, 24'h000080, 32'hCAFE_F00D},
    {2'd2, 1'b1, 24'h000080, 32'h0},
    {2'd1, 1'b1, 24'h000084, 32'h0},
    {2'd0, 1'b0, 24'h0000FC, 32'hFFFF_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [2:0]  wake_req, wake_ack;
  logic        tgt_req, tgt_we, tgt_ack;
  logic [23:0] tgt_addr;
  logic [31:0] tgt_wdata, tgt_rdata;

  logic [2:0]  hold = '0;
  logic [2:0]  exp_mask = '0;
  logic [2:0]  seen_req;
  logic [31:0] mem [64];
  logic [31:0] shadow [64];
  int          xfer_cnt, bad_order;
  logic [23:0] last_addr;
  logic        last_we;
  logic [31:0] last_wdata;
  int          checks = 0, errors = 0;

  regproxy_top u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .wake_req(wake_req),
    .wake_ack(wake_ack), .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .tgt_ack(tgt_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tgt_rdata = mem[tgt_addr[7:2]];

  // domain and target models plus monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      wake_ack  <= '0;
      tgt_ack   <= 1'b0;
      xfer_cnt  <= 0;
      bad_order <= 0;
      seen_req  <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= 32'h5A00_0000 + i;
    end else begin
      wake_ack <= wake_req & ~hold;
      tgt_ack  <= tgt_req && !tgt_ack;
      if (host_wr_en && host_addr == A_CMD) seen_req <= '0;
      else seen_req <= seen_req | wake_req;
      if (tgt_req && ((wake_ack & exp_mask) != exp_mask)) bad_order <= bad_order + 1;
      if (tgt_req && tgt_ack) begin
        xfer_cnt   <= xfer_cnt + 1;
        last_addr  <= tgt_addr;
        last_we    <= tgt_we;
        last_wdata <= tgt_wdata;
        if (tgt_we) mem[tgt_addr[7:2]] <= tgt_wdata;
      end
    end
  end

  function automatic logic [2:0] bench_mask(input logic [1:0] d);
    case (d)
      2'd0: return 3'b001;
      2'd1: return 3'b010;
      2'd2: return 3'b100;
      default: return 3'b111;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_go_low(input string req);
    logic [31:0] v;
    int n = 0;
    do begin
      host_read(A_CMD, v);
      n++;
    end while (v[31] && n < 200);
    check(req, {31'd0, v[31]}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    for (int i = 0; i < 64; i++) shadow[i] = 32'h5A00_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    host_read(A_DATA, v); check("R1 data", v, 32'd0);
    host_read(A_CMD, v);  check("R1 cmd", v, 32'd0);
    check("R1 wake_req", {29'd0, wake_req}, 32'd0);
    check("R1 tgt_req", {31'd0, tgt_req}, 32'd0);

    // vector walk: R3 R4 R5 R6 R7 R9
    for (int k = 0; k < NV; k++) begin
      logic [1:0]  d  = VEC[k][58:57];
      logic        rd = VEC[k][56];
      logic [23:0] o  = VEC[k][55:32];
      logic [31:0] w  = VEC[k][31:0];
      exp_mask = bench_mask(d);
      base = xfer_cnt;
      if (!rd) host_write(A_DATA, w);
      host_write(A_CMD, {1'b1, 1'b0, d, 3'b000, rd, o});
      wait_go_low("R7 go clears");
      check("R9 one handshake", xfer_cnt - base, 32'd1);
      check("R3 target offset", {8'd0, last_addr}, {8'd0, o});
      check("R3 write flag", {31'd0, last_we}, {31'd0, !rd});
      check("R5 wake mask", {29'd0, seen_req}, {29'd0, exp_mask});
      check("R7 wake dropped", {29'd0, wake_req}, 32'd0);
      if (rd) begin
        host_read(A_DATA, v);
        check("R4 read data", v, shadow[o[7:2]]);
      end else begin
        check("R3 write data", last_wdata, w);
        shadow[o[7:2]] = w;
      end
    end
    check("R6 ordering", bad_order, 32'd0);

    // R6/R8: stall media acknowledge, then try to overwrite both registers
    hold = 3'b100;
    exp_mask = 3'b100;
    host_read(A_DATA, v);
    base = xfer_cnt;
    host_write(A_CMD, {1'b1, 1'b0, 2'd2, 3'b000, 1'b1, 24'h000104});
    repeat (10) @(negedge clk);
    check("R6 stalled no xfer", xfer_cnt - base, 32'd0);
    check("R6 wake held", {29'd0, wake_req}, 32'd4);
    host_write(A_DATA, 32'hDEAD_BEEF);
    host_write(A_CMD, {1'b1, 1'b0, 2'd0, 3'b000, 1'b0, 24'h000010});
    host_read(A_DATA, v);  check("R8 data ignored", v, v == 32'hDEAD_BEEF ? 32'h0 : v);
    host_read(A_CMD, v);   check("R8 cmd ignored", v, 32'hA100_0104);
    hold = 3'b000;
    wait_go_low("R7 go clears after stall");
    check("R8 offset kept", {8'd0, last_addr}, 32'h0000_0104);
    check("R9 single after stall", xfer_cnt - base, 32'd1);
    host_read(A_DATA, v);  check("R4 stalled read data", v, shadow[6'h41 & 6'h3F]);
    check("R6 ordering stalled", bad_order, 32'd0);

    // R10 and R2: command without GO, reserved bits dropped
    base = xfer_cnt;
    host_write(A_CMD, 32'h7F00_0040);
    repeat (6) @(negedge clk);
    check("R10 no access", xfer_cnt - base, 32'd0);
    check("R10 no wake", {29'd0, wake_req}, 32'd0);
    host_read(A_CMD, v);   check("R2 reserved zero", v, 32'h3100_0040);
    host_write(A_DATA, 32'h0BAD_F00D);
    host_read(A_DATA, v);  check("R2 data writable idle", v, 32'h0BAD_F00D);
    host_read(12'h000, v); check("R2 unmapped", v, 32'd0);
    host_read(12'hF08, v); check("R2 unmapped high", v, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule